// File: doc/BRIEF.md
# NAND Target Command Front End

This block is the device side of a small-page NAND memory with an 8-bit multiplexed bus. It watches the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins. Each byte taken on a write strobe goes to one of three places: the command decoder, the address collector or the page buffer. Page read, page program with a confirm command, and status read are supported. The storage behind it is a small on-chip array of a few pages.

A host starts a read by sending a read command and four address bytes. It then waits for the ready/busy pin to return high, and pulls one byte per read-strobe pulse. A program has five steps: a program command, four address bytes, any number of data bytes, a confirm command, and the busy wait. The host can then ask for status. The bus has no valid/ready handshake, because the pin protocol is fixed. The only back-pressure is the ready/busy pin: the host must not send anything but a status command while it is low, and anything else sent then is dropped. The host must hold each byte on the bus across the rising write strobe and for two clocks after it. It must hold the read strobe low for at least three clocks.

Top module: `nand_fe`

## Requirements
- R1: While `ce_n` is low, a rising edge of `we_n` takes `io_in` as a command when `cle`=1 and `ale`=0, as an address byte when `ale`=1 and `cle`=0, and as a data byte when both are 0. A strobe with both high is ignored.
- R2: Read command 0x00 is followed by four address bytes. Byte 1 is the column. The low log2(PAGES) bits of byte 2 select the page. Higher row bits and bytes 3 and 4 are ignored, so out-of-range pages alias.
- R3: Read command 0x01 behaves like 0x00, except that the starting column is the address byte plus 256.
- R4: After the fourth address byte of a read, `rb` is low for exactly READ_BUSY clock cycles, then returns high.
- R5: After a read has finished its busy phase, each falling `re_n` returns the byte at the column pointer on `io_out` and advances the pointer. The pointer wraps from PAGE_BYTES-1 to 0. `io_oe` is high only while `ce_n` and `re_n` are both low and an output mode is active.
- R6: Program command 0x80 is followed by four address bytes (column in byte 1, page as in R2). Data bytes then fill consecutive columns. Confirm 0x10 makes `rb` low for exactly PROG_BUSY cycles.
- R7: A program stores old AND data into each written byte. Bytes not written keep their value.
- R8: After command 0x70, each read strobe returns the status of the last completed program: 0x00 when it succeeded, 0x01 when any written byte needed a bit to go from 0 to 1.
- R9: While `rb` is low, every command except 0x70 is ignored, and so are all address and data bytes.
- R10: While `ce_n` is high, all strobes are ignored, `io_oe` is low and the column pointer keeps its value.
- R11: After reset `rb` is 1, `io_oe` is 0, every array byte reads 0xFF and the status is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command-latch enable |
| ale | input | 1 | Address-latch enable |
| we_n | input | 1 | Write strobe; a byte is taken on its rising edge |
| re_n | input | 1 | Read strobe; a byte is fetched on its falling edge |
| io_in | input | 8 | Bus value driven by the host |
| io_out | output | 8 | Bus value driven by the block |
| io_oe | output | 1 | High when the block drives the bus |
| rb | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest case to reach from the pins is a stream of strobes arriving during a program's busy phase. A status command must be honoured and return the previous program's result. A read command with its address bytes must be dropped without disturbing the program in flight. The bench first runs a program built to fail, so the two status values differ. It then confirms a new program and, while `rb` is still low, sends a status request, a read and a full address. It checks that the status is the old one, that the new data landed, and that the final status is clean.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam logic [7:0] OP_READ_LO = 8'h00;
  localparam logic [7:0] OP_READ_HI = 8'h01;
  localparam logic [7:0] OP_PROG    = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam int         HALF_OFS   = 256;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_PDATA, S_RBUSY, S_PBUSY, S_RDATA
  } phase_t;

  typedef enum logic [1:0] {
    O_NONE, O_DATA, O_STAT
  } omode_t;
endpackage

// File: rtl/nand_fe_strobe.sv
module nand_fe_strobe (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic       cmd_stb,
  output logic       addr_stb,
  output logic       data_stb,
  output logic       rd_stb,
  output logic [7:0] byte_q
);
  logic we_q, re_q;
  logic wr_rise;

  assign wr_rise = !we_q && we_n && !ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      re_q     <= 1'b1;
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      data_stb <= 1'b0;
      rd_stb   <= 1'b0;
      byte_q   <= '0;
    end else begin
      we_q     <= we_n;
      re_q     <= re_n;
      cmd_stb  <= wr_rise && cle && !ale;
      addr_stb <= wr_rise && ale && !cle;
      data_stb <= wr_rise && !ale && !cle;
      rd_stb   <= re_q && !re_n && !ce_n;
      byte_q   <= io_in;
    end
  end
endmodule

// File: rtl/nand_fe_store.sv
module nand_fe_store #(
  parameter int PAGE_BYTES = 528,
  parameter int PAGES      = 4,
  localparam int CW   = $clog2(PAGE_BYTES),
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW   = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PG_W-1:0] page,
  input  logic            buf_we,
  input  logic [CW-1:0]   buf_col,
  input  logic [7:0]      buf_din,
  input  logic            merge_en,
  input  logic [CW-1:0]   merge_col,
  input  logic [CW-1:0]   rd_col,
  output logic [7:0]      rd_data,
  output logic            merge_fail
);
  logic [7:0] cells [PAGES*PAGE_BYTES];
  logic [7:0] pbuf  [PAGE_BYTES];
  logic       pmark [PAGE_BYTES];
  logic [AW-1:0] rd_idx, mg_idx;
  logic [7:0] old_b, new_b;

  assign rd_idx     = AW'(page) * AW'(PAGE_BYTES) + AW'(rd_col);
  assign mg_idx     = AW'(page) * AW'(PAGE_BYTES) + AW'(merge_col);
  assign rd_data    = cells[rd_idx];
  assign old_b      = cells[mg_idx];
  assign new_b      = pbuf[merge_col];
  assign merge_fail = pmark[merge_col] && (|(~old_b & new_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES*PAGE_BYTES; i++) cells[i] <= 8'hFF;
      for (int j = 0; j < PAGE_BYTES; j++) begin
        pbuf[j]  <= 8'hFF;
        pmark[j] <= 1'b0;
      end
    end else if (merge_en) begin
      cells[mg_idx]    <= old_b & new_b;
      pbuf[merge_col]  <= 8'hFF;
      pmark[merge_col] <= 1'b0;
    end else if (buf_we) begin
      pbuf[buf_col]  <= buf_din;
      pmark[buf_col] <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_fe_ctrl.sv
module nand_fe_ctrl
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int PAGES      = 4,
  parameter int READ_BUSY  = 12,
  parameter int PROG_BUSY  = 600,
  localparam int CW   = $clog2(PAGE_BYTES),
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int MAXB = (READ_BUSY > PROG_BUSY) ? READ_BUSY : PROG_BUSY,
  localparam int TW   = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_stb,
  input  logic            addr_stb,
  input  logic            data_stb,
  input  logic            rd_stb,
  input  logic [7:0]      byte_q,
  input  logic [7:0]      rd_data,
  input  logic            merge_fail,
  output logic            busy,
  output logic [PG_W-1:0] page,
  output logic            buf_we,
  output logic            merge_en,
  output logic [CW-1:0]   merge_col,
  output logic [CW-1:0]   col,
  output logic [7:0]      dout,
  output logic            out_on
);
  phase_t     st;
  omode_t     mode;
  logic [1:0] acnt;
  logic       op_rd, half;
  logic [TW-1:0] cnt;
  logic       fail_acc, fail_last;
  logic [CW-1:0] col_nx;

  assign busy      = (st == S_RBUSY) || (st == S_PBUSY);
  assign buf_we    = data_stb && (st == S_PDATA);
  assign merge_en  = (st == S_PBUSY) && (cnt < TW'(PAGE_BYTES));
  assign merge_col = CW'(cnt);
  assign out_on    = (mode != O_NONE);
  assign col_nx    = (col == CW'(PAGE_BYTES - 1)) ? '0 : col + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode      <= O_NONE;
      acnt      <= '0;
      op_rd     <= 1'b0;
      half      <= 1'b0;
      cnt       <= '0;
      fail_acc  <= 1'b0;
      fail_last <= 1'b0;
      page      <= '0;
      col       <= '0;
      dout      <= '0;
    end else begin
      // busy phases
      if (st == S_RBUSY) begin
        if (cnt == TW'(READ_BUSY - 1)) begin
          st   <= S_RDATA;
          mode <= O_DATA;
        end else cnt <= cnt + 1'b1;
      end
      if (st == S_PBUSY) begin
        fail_acc <= fail_acc | (merge_en && merge_fail);
        if (cnt == TW'(PROG_BUSY - 1)) begin
          st        <= S_IDLE;
          fail_last <= fail_acc | (merge_en && merge_fail);
        end else cnt <= cnt + 1'b1;
      end
      // command bytes
      if (cmd_stb) begin
        if (byte_q == OP_STATUS) mode <= O_STAT;
        else if (!busy) begin
          case (byte_q)
            OP_READ_LO, OP_READ_HI: begin
              op_rd <= 1'b1; half <= byte_q[0];
              st <= S_ADDR; acnt <= '0; mode <= O_NONE;
            end
            OP_PROG: begin
              op_rd <= 1'b0; half <= 1'b0;
              st <= S_ADDR; acnt <= '0; mode <= O_NONE;
            end
            OP_CONFIRM: if (st == S_PDATA) begin
              st <= S_PBUSY; cnt <= '0; fail_acc <= 1'b0;
            end
            default: ;
          endcase
        end
      end
      // address bytes
      if (addr_stb && st == S_ADDR) begin
        if (acnt == 2'd0) col  <= CW'(byte_q) + (half ? CW'(HALF_OFS) : '0);
        if (acnt == 2'd1) page <= byte_q[PG_W-1:0];
        acnt <= acnt + 1'b1;
        if (acnt == 2'd3) begin
          st  <= op_rd ? S_RBUSY : S_PDATA;
          cnt <= '0;
        end
      end
      // data bytes into the page buffer
      if (buf_we) col <= col_nx;
      // read strobes
      if (rd_stb) begin
        if (mode == O_STAT) dout <= {7'b0, fail_last};
        else if (mode == O_DATA && st == S_RDATA) begin
          dout <= rd_data;
          col  <= col_nx;
        end
      end
    end
  end
endmodule

// File: rtl/nand_fe.sv
module nand_fe #(
  parameter int PAGE_BYTES = 528,
  parameter int PAGES      = 4,
  parameter int READ_BUSY  = 12,
  parameter int PROG_BUSY  = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb
);
  localparam int CW   = $clog2(PAGE_BYTES);
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic cmd_stb, addr_stb, data_stb, rd_stb;
  logic [7:0] byte_q, rd_data;
  logic merge_fail, busy, buf_we, merge_en, out_on;
  logic [PG_W-1:0] page;
  logic [CW-1:0] merge_col, col;

  nand_fe_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in),
    .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb),
    .rd_stb(rd_stb), .byte_q(byte_q)
  );

  nand_fe_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES),
    .READ_BUSY(READ_BUSY), .PROG_BUSY(PROG_BUSY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .addr_stb(addr_stb),
    .data_stb(data_stb), .rd_stb(rd_stb), .byte_q(byte_q),
    .rd_data(rd_data), .merge_fail(merge_fail), .busy(busy), .page(page),
    .buf_we(buf_we), .merge_en(merge_en), .merge_col(merge_col),
    .col(col), .dout(io_out), .out_on(out_on)
  );

  nand_fe_store #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)) u_store (
    .clk(clk), .rst_n(rst_n), .page(page), .buf_we(buf_we),
    .buf_col(col), .buf_din(byte_q), .merge_en(merge_en),
    .merge_col(merge_col), .rd_col(col), .rd_data(rd_data),
    .merge_fail(merge_fail)
  );

  assign rb    = !busy;
  assign io_oe = !ce_n && !re_n && out_on;
endmodule

// File: rtl/nand_fe_chk.sv
module nand_fe_chk #(
  parameter int READ_BUSY = 12,
  parameter int PROG_BUSY = 600
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic re_n,
  input logic io_oe,
  input logic rb
);
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= 0;
    else if (!rb) low_run <= low_run + 1;
    else low_run <= 0;
  end

  // R4 / R6: a busy phase lasts exactly one of the two configured lengths
  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb) |-> (low_run == READ_BUSY || low_run == PROG_BUSY));

  // R4: busy never collapses after a single cycle
  a_r4_busy_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb) |=> !rb);

  // R10: deselected target never drives the bus
  a_r10_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !io_oe);

  // R5: bus is driven only inside a read strobe
  a_r5_oe_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> !re_n);
endmodule

bind nand_fe nand_fe_chk #(.READ_BUSY(READ_BUSY), .PROG_BUSY(PROG_BUSY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .io_oe(io_oe), .rb(rb)
);

// File: tb/nand_fe_test.sv
module nand_fe_test;
  localparam int PB  = 528;
  localparam int NP  = 4;
  localparam int RBZ = 12;
  localparam int PBZ = 600;

  // {page, column, data0, data1}
  localparam logic [31:0] VEC [7] = '{
    32'h00_00_AA_55, 32'h01_0A_0F_F0, 32'h01_0A_F0_F0, 32'h02_C8_12_34,
    32'h06_05_C3_3C, 32'h03_FE_01_80, 32'h00_01_FF_00
  };

  logic clk = 0, rst_n = 0, ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1;
  logic [7:0] io_in = 0, io_out;
  logic io_oe, rb;
  int nchk = 0, nfail = 0;
  logic [7:0] ref_mem [NP*PB];
  bit ref_fail = 0;

  always #2 clk = ~clk;

  nand_fe #(.PAGE_BYTES(PB), .PAGES(NP), .READ_BUSY(RBZ), .PROG_BUSY(PBZ)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb(rb)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io_in = b; we_n = 0;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (2) @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic rd(output logic [7:0] v, output logic oe);
    @(negedge clk); re_n = 0;
    repeat (3) @(negedge clk); v = io_out; oe = io_oe; re_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (rb == 0 && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic addr4(input int col, input int pg);
    wr(0, 1, 8'(col)); wr(0, 1, 8'(pg)); wr(0, 1, 8'h00); wr(0, 1, 8'h00);
  endtask

  task automatic prog2(input int pg, input int col, input logic [7:0] d0,
                       input logic [7:0] d1, output int n);
    int base;
    base = (pg % NP) * PB + col;
    wr(1, 0, 8'h80); addr4(col, pg); wr(0, 0, d0); wr(0, 0, d1); wr(1, 0, 8'h10);
    wait_ready(n);
    ref_fail = (|(~ref_mem[base] & d0)) || (|(~ref_mem[base+1] & d1));
    ref_mem[base]   = ref_mem[base] & d0;
    ref_mem[base+1] = ref_mem[base+1] & d1;
  endtask

  task automatic read_start(input bit hi, input int col, input int pg, output int n);
    wr(1, 0, hi ? 8'h01 : 8'h00); addr4(col, pg); wait_ready(n);
  endtask

  task automatic status(input string req, input int exp);
    logic [7:0] v; logic oe;
    wr(1, 0, 8'h70); rd(v, oe);
    chk(req, {oe, v}, {1'b1, 8'(exp)});
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v; logic oe; int n, pg, col, base;
    for (int i = 0; i < NP*PB; i++) ref_mem[i] = 8'hFF;
    repeat (4) @(negedge clk); rst_n = 1; @(negedge clk);

    // R11 reset state
    chk("R11 rb after reset", rb, 1);
    chk("R11 io_oe after reset", io_oe, 0);
    ce_n = 0;
    status("R11 status after reset", 0);
    read_start(0, 100, 3, n); rd(v, oe);
    chk("R11 erased byte", v, 8'hFF);

    // table walk: R2 R4 R6 R7 R8
    foreach (VEC[k]) begin
      pg = VEC[k][31:24]; col = VEC[k][23:16];
      base = (pg % NP) * PB + col;
      prog2(pg, col, VEC[k][15:8], VEC[k][7:0], n);
      chk("R6 program busy length", n, PBZ);
      status("R8 status after program", ref_fail);
      read_start(0, col, pg, n);
      chk("R4 read busy length", n, RBZ);
      rd(v, oe); chk("R7 R2 first byte", {oe, v}, {1'b1, ref_mem[base]});
      rd(v, oe); chk("R7 R5 second byte", {oe, v}, {1'b1, ref_mem[base+1]});
    end

    // R3 upper-half read
    prog2(2, 255, 8'h5A, 8'hA5, n);
    read_start(1, 0, 2, n); rd(v, oe);
    chk("R3 upper half column", v, ref_mem[2*PB+256]);

    // R5 wrap from last column to column 0
    read_start(1, 255, 0, n);
    for (int i = 511; i < PB; i++) begin
      rd(v, oe); chk("R5 tail column", v, ref_mem[i]);
    end
    rd(v, oe); chk("R5 wrap to column 0", v, ref_mem[0]);

    // R9 strobes during program busy
    prog2(0, 0, 8'hFF, 8'hFF, n);
    status("R8 failing program", 1);
    wr(1, 0, 8'h80); addr4(50, 3); wr(0, 0, 8'h11); wr(1, 0, 8'h10);
    chk("R9 busy after confirm", rb, 0);
    status("R9 status while busy keeps old result", 1);
    wr(1, 0, 8'h00); addr4(7, 1); wr(0, 0, 8'h00);
    wait_ready(n);
    ref_mem[3*PB+50] = 8'h11;
    status("R9 status after busy program", 0);
    read_start(0, 50, 3, n);
    rd(v, oe); chk("R9 programmed byte intact", v, 8'h11);
    rd(v, oe); chk("R9 neighbour untouched", v, 8'hFF);

    // R10 deselect keeps pointer, R1 both-latch strobe ignored
    read_start(0, 10, 1, n);
    rd(v, oe); chk("R10 byte before deselect", v, ref_mem[PB+10]);
    ce_n = 1;
    rd(v, oe); chk("R10 no drive when deselected", oe, 0);
    wr(1, 0, 8'h70);
    ce_n = 0;
    rd(v, oe); chk("R10 pointer kept", {oe, v}, {1'b1, ref_mem[PB+11]});
    wr(1, 1, 8'h70);
    rd(v, oe); chk("R1 both latches high ignored", v, ref_mem[PB+12]);

    finish_run();
  end
endmodule